// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN message is wanted and where it goes. It holds a bank of 32 filters and 4 shared acceptance masks. Each filter stores an enable, a standard identifier part, an extended identifier part, a flag that ties it to one frame format, a choice of one of the four masks, and the number of the receive FIFO that takes the messages it accepts.

A message is presented for one cycle as its 11-bit base identifier, its 18-bit identifier extension, its format bit and its first three data bytes. One clock later the block reports whether any enabled filter accepted it. On a hit it also gives the number of the lowest accepting filter and that filter's FIFO number. For standard-format messages, an optional data-compare count lets the leading data bits stand in for the unused extension field. This allows higher-layer addressing to be filtered in hardware.

Configuration arrives on direct write ports: one for filter contents, one for filter enables and one for masks. A filter's contents can only be changed while that filter is disabled.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every filter is disabled, every mask is zero, and `res_valid`, `res_hit`, `res_flt` and `res_fifo` read 0. A message presented before any filter is enabled is reported as a miss.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `msg_valid` = 1. In a cycle where `res_valid` is 0, the other result outputs are 0.
- R3: For each base identifier bit, a mask bit of 1 requires the message bit to equal the filter bit, and a mask bit of 0 makes that bit don't-care.
- R4: For an extended-format message (`msg_ide` = 1), each extension bit is compared against the filter's extension bit under the same mask rule.
- R5: When the selected mask's format bit is 1, a filter with extended flag 1 accepts only `msg_ide` = 1 and a filter with extended flag 0 accepts only `msg_ide` = 0. When the mask's format bit is 0, the message format is not checked.
- R6: When several enabled filters accept a message, `res_flt` reports the lowest-numbered of them and `res_fifo` reports that filter's FIFO number.
- R7: A disabled filter never accepts a message.
- R8: On a miss, `res_hit`, `res_flt` and `res_fifo` are 0.
- R9: For a standard-format message, a data-compare count N from 1 to 18 compares extension bit k (k < N) against data bit k. Data bit k is bit 7-(k mod 8) of byte k/8, where byte 0 is `msg_data[7:0]`, byte 1 is `msg_data[15:8]` and byte 2 is `msg_data[23:16]`. Extension bits at or above N are don't-care. A count of 0 makes all extension bits don't-care. An extended-format message ignores the data bytes and the count.
- R10: A data-compare count of 19 or more behaves as 18.
- R11: A write of filter contents (identifier parts, extended flag, mask choice, FIFO number) to a filter that is currently enabled is ignored.
- R12: Each filter uses the mask whose index equals its 2-bit mask choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write filter contents |
| cfg_idx | input | 5 | Filter written by `cfg_we` |
| cfg_sid | input | 11 | Base identifier to store |
| cfg_eid | input | 18 | Extension identifier to store |
| cfg_ext | input | 1 | Extended-format flag to store |
| cfg_msel | input | 2 | Mask choice to store |
| cfg_fifo | input | 5 | Destination FIFO number to store |
| en_we | input | 1 | Write a filter enable |
| en_idx | input | 5 | Filter whose enable is written |
| en_val | input | 1 | New enable value |
| msk_we | input | 1 | Write a mask |
| msk_idx | input | 2 | Mask written |
| msk_sid | input | 11 | Base identifier compare bits |
| msk_eid | input | 18 | Extension compare bits |
| msk_ide | input | 1 | Format-check bit |
| dn_count | input | 5 | Data-compare bit count for standard messages |
| msg_valid | input | 1 | Message presented this cycle |
| msg_sid | input | 11 | Message base identifier |
| msg_eid | input | 18 | Message extension identifier |
| msg_ide | input | 1 | Message format, 1 = extended |
| msg_data | input | 24 | First three data bytes, byte 0 in the low bits |
| res_valid | output | 1 | Result for the message of the previous cycle |
| res_hit | output | 1 | Some enabled filter accepted the message |
| res_flt | output | 5 | Lowest accepting filter |
| res_fifo | output | 5 | FIFO number of that filter |

## Verification
The bench builds overlapping filters so that two enabled filters hold the same identifier, and a catch-all filter sits above a narrower one. A priority encoder that favoured high indices, or one that reported the first match in write order, would return the wrong filter number. The data-bit checks use an asymmetric byte and step the count across the boundary bits at 16, 17 and 18 and above 18. A reversed bit order, an off-by-one count, or a count above 18 treated as zero would each flip one of those hit/miss results. Writes aimed at an enabled filter are followed by messages that would only hit if the write had landed. Format checks present both formats under masks that do and do not check the format.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int SID_W  = 11;
  localparam int EID_W  = 18;
  localparam int DATA_W = 24;
  localparam int DNC_W  = 5;

  typedef struct packed {
    logic [SID_W-1:0] sid;
    logic [EID_W-1:0] eid;
    logic             ide;
  } mask_t;

  // Leading data bits in bus order: stream bit k = byte k/8, bit 7-(k mod 8)
  function automatic logic [EID_W-1:0] dn_stream(input logic [DATA_W-1:0] d);
    logic [EID_W-1:0] s;
    for (int k = 0; k < EID_W; k++) s[k] = d[(k / 8) * 8 + 7 - (k % 8)];
    return s;
  endfunction

  // Care vector with the low min(n, EID_W) bits set
  function automatic logic [EID_W-1:0] dn_care(input logic [DNC_W-1:0] n);
    logic [EID_W-1:0] c;
    int lim;
    lim = (int'(n) > EID_W) ? EID_W : int'(n);
    for (int k = 0; k < EID_W; k++) c[k] = (k < lim);
    return c;
  endfunction
endpackage

// File: rtl/can_flt_mask_bank.sv
module can_flt_mask_bank
  import can_flt_pkg::*;
#(
  parameter int NUM_MSK = 4,
  localparam int MW = $clog2(NUM_MSK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [MW-1:0]        idx,
  input  logic [SID_W-1:0]     sid,
  input  logic [EID_W-1:0]     eid,
  input  logic                 ide,
  output mask_t                masks [NUM_MSK]
);
  for (genvar m = 0; m < NUM_MSK; m++) begin : g_msk
    always_ff @(posedge clk) begin
      if (!rst_n) masks[m] <= '0;
      else if (we && idx == MW'(m)) masks[m] <= '{sid: sid, eid: eid, ide: ide};
    end
  end
endmodule

// File: rtl/can_flt_entry.sv
module can_flt_entry
  import can_flt_pkg::*;
#(
  parameter int NUM_MSK = 4,
  parameter int FIFO_W  = 5,
  localparam int MW = $clog2(NUM_MSK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SID_W-1:0]  cfg_sid,
  input  logic [EID_W-1:0]  cfg_eid,
  input  logic              cfg_ext,
  input  logic [MW-1:0]     cfg_msel,
  input  logic [FIFO_W-1:0] cfg_fifo,
  input  logic              en_we,
  input  logic              en_val,
  input  mask_t             masks [NUM_MSK],
  input  logic [SID_W-1:0]  msg_sid,
  input  logic [EID_W-1:0]  msg_eid,
  input  logic              msg_ide,
  input  logic [EID_W-1:0]  dn_bits,
  input  logic [EID_W-1:0]  dn_sel,
  output logic              match,
  output logic [FIFO_W-1:0] fifo_out
);
  logic              f_en;
  logic [SID_W-1:0]  f_sid;
  logic [EID_W-1:0]  f_eid;
  logic              f_ext;
  logic [MW-1:0]     f_msel;
  logic [FIFO_W-1:0] f_fifo;

  // contents load only while the filter is off
  logic cfg_take;
  assign cfg_take = cfg_we && !f_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_en   <= 1'b0;
      f_sid  <= '0;
      f_eid  <= '0;
      f_ext  <= 1'b0;
      f_msel <= '0;
      f_fifo <= '0;
    end else begin
      if (en_we) f_en <= en_val;
      if (cfg_take) begin
        f_sid  <= cfg_sid;
        f_eid  <= cfg_eid;
        f_ext  <= cfg_ext;
        f_msel <= cfg_msel;
        f_fifo <= cfg_fifo;
      end
    end
  end

  mask_t mk;
  logic  sid_ok, eid_ok, typ_ok;

  always_comb begin
    mk     = masks[f_msel];
    sid_ok = ((f_sid ^ msg_sid) & mk.sid) == '0;
    if (msg_ide) eid_ok = ((f_eid ^ msg_eid) & mk.eid) == '0;
    else         eid_ok = ((f_eid ^ dn_bits) & mk.eid & dn_sel) == '0;
    typ_ok = !mk.ide || (f_ext == msg_ide);
    match  = f_en && sid_ok && eid_ok && typ_ok;
  end

  assign fifo_out = f_fifo;

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && f_en) |=> ($stable(f_sid) && $stable(f_eid) && $stable(f_ext)
                          && $stable(f_msel) && $stable(f_fifo)));
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
  parameter int NUM_FLT = 32,
  localparam int IW = $clog2(NUM_FLT)
) (
  input  logic [NUM_FLT-1:0] vec,
  output logic               any,
  output logic [IW-1:0]      idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_FLT = 32,
  parameter int NUM_MSK = 4,
  parameter int FIFO_W  = 5,
  localparam int IW = $clog2(NUM_FLT),
  localparam int MW = $clog2(NUM_MSK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [SID_W-1:0]  cfg_sid,
  input  logic [EID_W-1:0]  cfg_eid,
  input  logic              cfg_ext,
  input  logic [MW-1:0]     cfg_msel,
  input  logic [FIFO_W-1:0] cfg_fifo,
  input  logic              en_we,
  input  logic [IW-1:0]     en_idx,
  input  logic              en_val,
  input  logic              msk_we,
  input  logic [MW-1:0]     msk_idx,
  input  logic [SID_W-1:0]  msk_sid,
  input  logic [EID_W-1:0]  msk_eid,
  input  logic              msk_ide,
  input  logic [DNC_W-1:0]  dn_count,
  input  logic              msg_valid,
  input  logic [SID_W-1:0]  msg_sid,
  input  logic [EID_W-1:0]  msg_eid,
  input  logic              msg_ide,
  input  logic [DATA_W-1:0] msg_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IW-1:0]     res_flt,
  output logic [FIFO_W-1:0] res_fifo
);
  localparam logic [NUM_FLT-1:0] ONE = NUM_FLT'(1);

  mask_t              masks [NUM_MSK];
  logic [EID_W-1:0]   dn_bits, dn_sel;
  logic [NUM_FLT-1:0] match_vec;
  logic [FIFO_W-1:0]  fifo_of [NUM_FLT];
  logic               win_any;
  logic [IW-1:0]      win_idx;

  can_flt_mask_bank #(.NUM_MSK(NUM_MSK)) u_masks (
    .clk(clk), .rst_n(rst_n), .we(msk_we), .idx(msk_idx),
    .sid(msk_sid), .eid(msk_eid), .ide(msk_ide), .masks(masks)
  );

  // data bits shared by every filter
  assign dn_bits = dn_stream(msg_data);
  assign dn_sel  = dn_care(dn_count);

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    can_flt_entry #(.NUM_MSK(NUM_MSK), .FIFO_W(FIFO_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we && cfg_idx == IW'(f)),
      .cfg_sid(cfg_sid), .cfg_eid(cfg_eid), .cfg_ext(cfg_ext),
      .cfg_msel(cfg_msel), .cfg_fifo(cfg_fifo),
      .en_we(en_we && en_idx == IW'(f)), .en_val(en_val),
      .masks(masks),
      .msg_sid(msg_sid), .msg_eid(msg_eid), .msg_ide(msg_ide),
      .dn_bits(dn_bits), .dn_sel(dn_sel),
      .match(match_vec[f]), .fifo_out(fifo_of[f])
    );
  end

  can_flt_prio #(.NUM_FLT(NUM_FLT)) u_prio (
    .vec(match_vec), .any(win_any), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_flt   <= '0;
      res_fifo  <= '0;
    end else begin
      res_valid <= msg_valid;
      res_hit   <= msg_valid && win_any;
      res_flt   <= (msg_valid && win_any) ? win_idx : '0;
      res_fifo  <= (msg_valid && win_any) ? fifo_of[win_idx] : '0;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> res_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> (!res_valid && !res_hit && res_flt == '0 && res_fifo == '0));
  // R6
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> ((($past(match_vec) >> res_flt) & ONE) == ONE
                 && ($past(match_vec) & ((ONE << res_flt) - ONE)) == '0));
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_flt == '0 && res_fifo == '0
                                 && $past(match_vec) == '0));
endmodule

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, en_we = 0, en_val = 0, msk_we = 0, msk_ide = 0;
  logic [4:0]  cfg_idx = 0, en_idx = 0, cfg_fifo = 0, dn_count = 0;
  logic [10:0] cfg_sid = 0, msk_sid = 0, msg_sid = 0;
  logic [17:0] cfg_eid = 0, msk_eid = 0, msg_eid = 0;
  logic        cfg_ext = 0, msg_valid = 0, msg_ide = 0;
  logic [1:0]  cfg_msel = 0, msk_idx = 0;
  logic [23:0] msg_data = 0;
  logic        res_valid, res_hit;
  logic [4:0]  res_flt, res_fifo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_accept_filter u_can_accept_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sid(cfg_sid), .cfg_eid(cfg_eid),
    .cfg_ext(cfg_ext), .cfg_msel(cfg_msel), .cfg_fifo(cfg_fifo),
    .en_we(en_we), .en_idx(en_idx), .en_val(en_val),
    .msk_we(msk_we), .msk_idx(msk_idx), .msk_sid(msk_sid), .msk_eid(msk_eid),
    .msk_ide(msk_ide), .dn_count(dn_count),
    .msg_valid(msg_valid), .msg_sid(msg_sid), .msg_eid(msg_eid),
    .msg_ide(msg_ide), .msg_data(msg_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_flt(res_flt), .res_fifo(res_fifo)
  );

  typedef struct packed {
    logic [10:0] sid;
    logic [17:0] eid;
    logic        ide;
    logic [23:0] data;
    logic [4:0]  dnc;
    logic        hit;
    logic [4:0]  flt;
    logic [4:0]  fifo;
    logic [4:0]  req;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{11'h123, 18'h0,     1'b0, 24'h000000, 5'd0,  1'b1, 5'd2, 5'd7,  5'd3},  // R3 R6
    '{11'h124, 18'h0,     1'b0, 24'h000000, 5'd0,  1'b0, 5'd0, 5'd0,  5'd8},  // R8
    '{11'h1A5, 18'h23456, 1'b1, 24'h000000, 5'd0,  1'b1, 5'd5, 5'd9,  5'd4},  // R4
    '{11'h1A5, 18'h23457, 1'b1, 24'h000000, 5'd0,  1'b0, 5'd0, 5'd0,  5'd4},  // R4
    '{11'h1A5, 18'h23456, 1'b0, 24'h000000, 5'd0,  1'b0, 5'd0, 5'd0,  5'd5},  // R5
    '{11'h34B, 18'h0,     1'b0, 24'h000000, 5'd0,  1'b1, 5'd7, 5'd3,  5'd12}, // R12
    '{11'h34F, 18'h12345, 1'b1, 24'h000000, 5'd0,  1'b1, 5'd7, 5'd3,  5'd5},  // R5
    '{11'h123, 18'h0,     1'b1, 24'h000000, 5'd0,  1'b0, 5'd0, 5'd0,  5'd5},  // R5
    '{11'h050, 18'h0,     1'b0, 24'h000000, 5'd0,  1'b1, 5'd9, 5'd12, 5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'h0000C1, 5'd8,  1'b1, 5'd9, 5'd12, 5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'h000083, 5'd8,  1'b0, 5'd0, 5'd0,  5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'h0000C1, 5'd17, 1'b0, 5'd0, 5'd0,  5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'h0000C1, 5'd16, 1'b1, 5'd9, 5'd12, 5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'h8000C1, 5'd18, 1'b1, 5'd9, 5'd12, 5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'hC000C1, 5'd18, 1'b0, 5'd0, 5'd0,  5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'hC000C1, 5'd31, 1'b0, 5'd0, 5'd0,  5'd10}, // R10
    '{11'h050, 18'h0,     1'b0, 24'hBF00C1, 5'd31, 1'b1, 5'd9, 5'd12, 5'd10}, // R10
    '{11'h050, 18'h10083, 1'b1, 24'hFFFFFF, 5'd8,  1'b1, 5'd9, 5'd12, 5'd9},  // R9
    '{11'h050, 18'h0,     1'b0, 24'hC000C1, 5'd19, 1'b0, 5'd0, 5'd0,  5'd10}, // R10
    '{11'h050, 18'h0,     1'b0, 24'hBF00C1, 5'd19, 1'b1, 5'd9, 5'd12, 5'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_flt(input logic [4:0] i, input logic [10:0] s, input logic [17:0] e,
                        input logic x, input logic [1:0] m, input logic [4:0] f);
    @(negedge clk);
    cfg_we = 1; cfg_idx = i; cfg_sid = s; cfg_eid = e; cfg_ext = x; cfg_msel = m; cfg_fifo = f;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_en(input logic [4:0] i, input logic v);
    @(negedge clk);
    en_we = 1; en_idx = i; en_val = v;
    @(negedge clk);
    en_we = 0;
  endtask

  task automatic wr_msk(input logic [1:0] i, input logic [10:0] s, input logic [17:0] e,
                        input logic d);
    @(negedge clk);
    msk_we = 1; msk_idx = i; msk_sid = s; msk_eid = e; msk_ide = d;
    @(negedge clk);
    msk_we = 0;
  endtask

  // present one message; outputs are sampled at the following falling edge
  task automatic send(input logic [10:0] s, input logic [17:0] e, input logic d,
                      input logic [23:0] dat, input logic [4:0] n);
    @(negedge clk);
    msg_valid = 1; msg_sid = s; msg_eid = e; msg_ide = d; msg_data = dat; dn_count = n;
    @(negedge clk);
    msg_valid = 0;
  endtask

  function automatic logic [31:0] pack_res();
    return {20'd0, res_valid, res_hit, res_flt, res_fifo};
  endfunction

  function automatic logic [31:0] exp_res(input logic h, input logic [4:0] f, input logic [4:0] q);
    return {20'd0, 1'b1, h, f, q};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {28'd0, res_valid, res_hit, 2'd0}, 32'd0);
    send(11'h123, 18'h0, 1'b0, 24'h0, 5'd0);
    check("R1 miss with no filter", pack_res(), exp_res(1'b0, 5'd0, 5'd0));
    @(negedge clk);
    // R2 valid drops
    check("R2 valid low after idle", {31'd0, res_valid}, 32'd0);

    wr_msk(2'd0, 11'h7FF, 18'h3FFFF, 1'b1);
    wr_msk(2'd1, 11'h7F0, 18'h00000, 1'b0);
    wr_msk(2'd2, 11'h7FF, 18'h3FFFF, 1'b0);
    wr_msk(2'd3, 11'h000, 18'h00000, 1'b0);
    wr_flt(5'd2,  11'h123, 18'h0,     1'b0, 2'd0, 5'd7);
    wr_flt(5'd4,  11'h123, 18'h0,     1'b0, 2'd0, 5'd20);
    wr_flt(5'd5,  11'h1A5, 18'h23456, 1'b1, 2'd0, 5'd9);
    wr_flt(5'd7,  11'h340, 18'h0,     1'b0, 2'd1, 5'd3);
    wr_flt(5'd9,  11'h050, 18'h10083, 1'b0, 2'd2, 5'd12);
    wr_flt(5'd30, 11'h000, 18'h0,     1'b0, 2'd3, 5'd31);
    set_en(5'd2, 1); set_en(5'd4, 1); set_en(5'd5, 1); set_en(5'd7, 1); set_en(5'd9, 1);

    foreach (VECS[i]) begin
      send(VECS[i].sid, VECS[i].eid, VECS[i].ide, VECS[i].data, VECS[i].dnc);
      n_chk++;
      if (pack_res() !== exp_res(VECS[i].hit, VECS[i].flt, VECS[i].fifo)) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h", VECS[i].req, i,
                 pack_res(), exp_res(VECS[i].hit, VECS[i].flt, VECS[i].fifo));
      end
    end

    // R11 write to an enabled filter is dropped
    wr_flt(5'd5, 11'h111, 18'h23456, 1'b1, 2'd0, 5'd10);
    send(11'h1A5, 18'h23456, 1'b1, 24'h0, 5'd0);
    check("R11 old contents kept", pack_res(), exp_res(1'b1, 5'd5, 5'd9));
    send(11'h111, 18'h23456, 1'b1, 24'h0, 5'd0);
    check("R11 new id not loaded", pack_res(), exp_res(1'b0, 5'd0, 5'd0));
    set_en(5'd5, 0);
    wr_flt(5'd5, 11'h111, 18'h23456, 1'b1, 2'd0, 5'd10);
    set_en(5'd5, 1);
    send(11'h111, 18'h23456, 1'b1, 24'h0, 5'd0);
    check("R11 write while disabled lands", pack_res(), exp_res(1'b1, 5'd5, 5'd10));

    // R7 disabled filters drop out
    set_en(5'd2, 0);
    send(11'h123, 18'h0, 1'b0, 24'h0, 5'd0);
    check("R7 next filter takes over", pack_res(), exp_res(1'b1, 5'd4, 5'd20));
    set_en(5'd4, 0);
    send(11'h123, 18'h0, 1'b0, 24'h0, 5'd0);
    check("R7 all disabled miss", pack_res(), exp_res(1'b0, 5'd0, 5'd0));

    // R6 catch-all at a high index loses to a lower match
    set_en(5'd30, 1);
    send(11'h7FF, 18'h0, 1'b0, 24'h0, 5'd0);
    check("R6 catch-all alone", pack_res(), exp_res(1'b1, 5'd30, 5'd31));
    send(11'h34B, 18'h0, 1'b0, 24'h0, 5'd0);
    check("R6 lower filter wins", pack_res(), exp_res(1'b1, 5'd7, 5'd3));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule